// File: doc/BRIEF.md
# Edge-Interval Preamble Validator

This block sits behind a demodulator and decides whether activity on the demodulated data line comes from a real transmitter or from noise. After a wake request it runs a fixed start-up delay. It then measures, in clock cycles, the spacing between successive edges of the synchronised input. Each spacing is compared against a lower and an upper cycle limit.

A run of good spacings of the selected length moves the block into its receive state, where the input is forwarded to `data_out`. One spacing that is too short, or too long, sends the block back to sleep at once. A too-long spacing is detected while the block is still waiting, as soon as the count passes the upper limit. The preamble length is picked in whole bits. Each bit is taken to carry two edges, so every selected bit needs two good spacings.

The limits and the bit selection are captured when the wake request is accepted. Later changes on those inputs do not affect a check that is already running. The block stays in the receive state until reset.

Top module: `preamble_validator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `state_o` reads 0 (sleep) and `data_out` is 0.
- R2: In sleep, a high `wake` moves `state_o` to 1 (start-up) on the next edge. Start-up lasts STARTUP_CYCLES cycles. `wake` is ignored in every state other than sleep.
- R3: `bit_sel` values 0, 1, 2 and 3 select 0, 3, 6 and 9 bits. The block needs 0, 6, 12 or 18 good spacings. With 0 it goes from start-up straight to receive (3) and never enters check (2).
- R4: The first synchronised edge seen in the check state (2) only starts the interval count. It is never judged, however soon after start-up it arrives.
- R5: A spacing d between consecutive edges in the check state counts as good when lim_lo <= d <= lim_hi. Both limits are inclusive.
- R6: A spacing shorter than lim_lo returns the block to sleep (0) straight away.
- R7: Once the interval count reaches lim_hi+1 with no edge, the block returns to sleep on the next clock. Counted from the input change that started the interval, the state is still 2 after lim_hi+3 clocks and is 0 after lim_hi+4.
- R8: When the required number of good spacings is reached, `state_o` becomes 3 (receive) and stays there until reset.
- R9: `data_out` is 0 in every state except receive. In receive it equals `rx_in` delayed by three clocks.
- R10: `lim_lo`, `lim_hi` and `bit_sel` are captured when wake is accepted. Changing them afterwards has no effect on the check that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | Activation request, honoured only in sleep |
| rx_in | input | 1 | Demodulated data line, asynchronous |
| bit_sel | input | 2 | Preamble length select: 0/3/6/9 bits |
| lim_lo | input | LIM_W | Shortest accepted edge spacing, in cycles |
| lim_hi | input | LIM_W | Longest accepted edge spacing, in cycles |
| data_out | output | 1 | Forwarded data, low unless receiving |
| state_o | output | 2 | 0 sleep, 1 start-up, 2 check, 3 receive |

## Verification
The bench aims at the inclusive window edges. It uses spacings of exactly lim_lo and lim_hi, which must pass, and lim_lo-1 and lim_hi+1, which must fail. A design with an off-by-one comparison would reject valid preambles or admit noise. It pins the cycle of the timeout, which a design that only judges at the next edge would miss entirely. It also sends an edge immediately after start-up; a design that judged that first edge would drop to sleep.

Further directed cases cover a zero-bit selection, a wake pulse during the check, and limits changed in mid-check. A block that re-sampled its configuration would then take the wrong decision. Random preambles around the window cover the rest. Each run is compared with a bench function that computes whether the first 6*bit_sel spacings all fit.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [1:0] {
    PV_SLEEP  = 2'd0,
    PV_WARMUP = 2'd1,
    PV_CHECK  = 2'd2,
    PV_RECV   = 2'd3
  } pv_state_e;
endpackage

// File: rtl/pv_edge_sync.sv
module pv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic sync_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign sync_o = chain_q[STAGES-1];
  assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pv_interval_timer.sv
module pv_interval_timer #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             edge_i,
  input  logic [LIM_W-1:0] lo,
  input  logic [LIM_W-1:0] hi,
  output logic             edge_ok,
  output logic             edge_bad,
  output logic             overrun
);
  localparam int CW = LIM_W + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          in_win;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q   <= CW'(1);
      armed_q <= 1'b1;
    end else if (cnt_q != CMAX) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign in_win   = (cnt_q >= {1'b0, lo}) && (cnt_q <= {1'b0, hi});
  assign edge_ok  = run && armed_q && edge_i && in_win;
  assign edge_bad = run && armed_q && edge_i && !in_win;
  assign overrun  = run && armed_q && !edge_i && (cnt_q > {1'b0, hi});

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (run && !edge_i && cnt_q == CMAX) |=> (!run || cnt_q == CMAX || $past(edge_i))); // R7
  AST_FIRST_EDGE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (run && !armed_q) |-> (!edge_ok && !edge_bad && !overrun)); // R4
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({edge_ok, edge_bad, overrun}) <= 1); // R5
endmodule

// File: rtl/pv_ctrl.sv
module pv_ctrl
  import pv_pkg::*;
#(
  parameter int LIM_W          = 8,
  parameter int STARTUP_CYCLES = 16,
  parameter int BIT_STEP       = 3,
  parameter int EDGES_PER_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake,
  input  logic [1:0]       bit_sel,
  input  logic [LIM_W-1:0] lim_lo_in,
  input  logic [LIM_W-1:0] lim_hi_in,
  input  logic             edge_ok,
  input  logic             edge_bad,
  input  logic             overrun,
  output pv_state_e        state_o,
  output logic [LIM_W-1:0] lim_lo_q,
  output logic [LIM_W-1:0] lim_hi_q,
  output logic             run
);
  localparam int PER_SEL = BIT_STEP * EDGES_PER_BIT;
  localparam int GW      = $clog2(3 * PER_SEL + 1);
  localparam int SW      = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;

  pv_state_e     state_q;
  logic [SW-1:0] su_q;
  logic [GW-1:0] need_q;
  logic [GW-1:0] good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PV_SLEEP;
      su_q     <= '0;
      need_q   <= '0;
      good_q   <= '0;
      lim_lo_q <= '0;
      lim_hi_q <= '0;
    end else begin
      case (state_q)
        PV_SLEEP: begin
          if (wake) begin
            state_q  <= PV_WARMUP;
            su_q     <= SW'(STARTUP_CYCLES - 1);
            need_q   <= GW'(int'(bit_sel) * PER_SEL);
            lim_lo_q <= lim_lo_in;
            lim_hi_q <= lim_hi_in;
            good_q   <= '0;
          end
        end
        PV_WARMUP: begin
          if (su_q == '0) begin
            state_q <= (need_q == '0) ? PV_RECV : PV_CHECK;
          end else begin
            su_q <= su_q - 1'b1;
          end
        end
        PV_CHECK: begin
          if (edge_bad || overrun) begin
            state_q <= PV_SLEEP;
          end else if (edge_ok) begin
            if (GW'(good_q + 1'b1) == need_q) state_q <= PV_RECV;
            good_q <= good_q + 1'b1;
          end
        end
        default: state_q <= PV_RECV;
      endcase
    end
  end

  assign state_o = state_q;
  assign run     = (state_q == PV_CHECK);

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == PV_SLEEP && !wake) |=> state_q == PV_SLEEP); // R2
  AST_FAIL_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == PV_CHECK && (edge_bad || overrun)) |=> state_q == PV_SLEEP); // R6
  AST_RECV_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == PV_RECV) |=> state_q == PV_RECV); // R8
  AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == PV_WARMUP && need_q == '0) |=> state_q != PV_CHECK); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q != PV_SLEEP && $past(state_q) != PV_SLEEP) |-> $stable(lim_hi_q)); // R10
endmodule

// File: rtl/preamble_validator.sv
module preamble_validator
  import pv_pkg::*;
#(
  parameter int LIM_W          = 8,
  parameter int STARTUP_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake,
  input  logic             rx_in,
  input  logic [1:0]       bit_sel,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic [LIM_W-1:0] lim_hi,
  output logic             data_out,
  output logic [1:0]       state_o
);
  pv_state_e        st;
  logic             rx_s, rx_edge, run;
  logic             e_ok, e_bad, e_over;
  logic [LIM_W-1:0] lo_q, hi_q;

  pv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .sync_o(rx_s), .edge_o(rx_edge)
  );

  pv_interval_timer #(.LIM_W(LIM_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .edge_i(rx_edge),
    .lo(lo_q), .hi(hi_q),
    .edge_ok(e_ok), .edge_bad(e_bad), .overrun(e_over)
  );

  pv_ctrl #(
    .LIM_W(LIM_W), .STARTUP_CYCLES(STARTUP_CYCLES),
    .BIT_STEP(3), .EDGES_PER_BIT(2)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wake(wake), .bit_sel(bit_sel),
    .lim_lo_in(lim_lo), .lim_hi_in(lim_hi),
    .edge_ok(e_ok), .edge_bad(e_bad), .overrun(e_over),
    .state_o(st), .lim_lo_q(lo_q), .lim_hi_q(hi_q), .run(run)
  );

  always_ff @(posedge clk) begin
    if (rst) data_out <= 1'b0;
    else     data_out <= (st == PV_RECV) ? rx_s : 1'b0;
  end

  assign state_o = st;

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st != PV_RECV) |=> !data_out); // R9
  AST_DATA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (st == PV_RECV) |=> data_out == $past(rx_s)); // R9
endmodule

// File: tb/preamble_validator_test.sv
module preamble_validator_test;
  localparam int SU = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake = 1'b0;
  logic       rx_in = 1'b0;
  logic [1:0] bit_sel = 2'd1;
  logic [7:0] lim_lo = 8'd4;
  logic [7:0] lim_hi = 8'd8;
  logic       data_out;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  int iv [0:31];

  always #2 clk = ~clk;

  preamble_validator #(.LIM_W(8), .STARTUP_CYCLES(SU), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .wake(wake), .rx_in(rx_in), .bit_sel(bit_sel),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .data_out(data_out), .state_o(state_o)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wake = 1'b0; rx_in = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic start(input logic [1:0] b, input int lo, input int hi);
    bit_sel = b; lim_lo = 8'(lo); lim_hi = 8'(hi);
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(SU + 2);
  endtask

  task automatic toggle();
    rx_in = ~rx_in;
  endtask

  function automatic int expect_recv(input int need, input int lo, input int hi, input int n);
    for (int i = 0; i < need; i++) begin
      if (i >= n) return 2;
      if (iv[i] < lo || iv[i] > hi) return 0;
    end
    return 3;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk("R1 state in reset", state_o, 0);
    chk("R1 data in reset", data_out, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 state after reset", state_o, 0);
    chk("R1 data after reset", data_out, 0);

    // R2 start-up timing
    bit_sel = 2'd1; lim_lo = 8'd4; lim_hi = 8'd8;
    wake = 1'b1; tick(1); wake = 1'b0;
    chk("R2 enters start-up", state_o, 1);
    tick(SU - 1);
    chk("R2 still start-up", state_o, 1);
    tick(1);
    chk("R2 reaches check", state_o, 2);
    // R2 wake ignored in check
    wake = 1'b1; tick(2); wake = 1'b0;
    chk("R2 wake ignored in check", state_o, 2);
    chk("R9 data low in check", data_out, 0);

    // R7 timeout timing, hi = 8
    toggle();
    tick(8 + 3);
    chk("R7 still check at hi+3", state_o, 2);
    tick(1);
    chk("R7 sleep at hi+4", state_o, 0);

    // R3 zero bits skip check
    do_reset();
    bit_sel = 2'd0;
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(SU - 1);
    chk("R3 zero bits start-up", state_o, 1);
    tick(1);
    chk("R3 zero bits receive", state_o, 3);

    // R9 data follow with three clock latency
    rx_in = 1'b1; tick(2);
    chk("R9 data before latency", data_out, 0);
    tick(1);
    chk("R9 data after latency", data_out, 1);
    rx_in = 1'b0; tick(3);
    chk("R9 data follows low", data_out, 0);
    // R2 wake ignored in receive
    wake = 1'b1; tick(2); wake = 1'b0;
    chk("R2 wake ignored in receive", state_o, 3);

    // R4 early arming edge; R5 exact bounds pass; R8 receive stays
    do_reset();
    bit_sel = 2'd1;
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(SU);
    toggle();
    tick(1);
    chk("R4 first edge not judged", state_o, 2);
    tick(4);
    for (int i = 0; i < 6; i++) begin
      toggle();
      tick((i % 2 == 0) ? 5 : 9);
      if (i < 5) begin
        toggle(); tick(0);
      end
    end
    do_reset();
    start(2'd1, 5, 9);
    toggle();
    for (int i = 0; i < 6; i++) begin
      tick((i % 2 == 0) ? 5 : 9);
      toggle();
    end
    tick(3);
    chk("R5 exact lo and hi pass", state_o, 3);
    tick(40);
    chk("R8 receive holds", state_o, 3);

    // R6 short spacing fails
    do_reset();
    start(2'd2, 6, 10);
    toggle(); tick(7); toggle(); tick(5); toggle();
    tick(3);
    chk("R6 lo-1 spacing sleeps", state_o, 0);

    // R5 hi+1 spacing fails
    do_reset();
    start(2'd1, 6, 10);
    toggle(); tick(11); toggle();
    tick(3);
    chk("R5 hi+1 spacing sleeps", state_o, 0);

    // R10 limits changed during check
    do_reset();
    start(2'd1, 10, 20);
    lim_lo = 8'd1; lim_hi = 8'd2; bit_sel = 2'd3;
    toggle();
    for (int i = 0; i < 6; i++) begin
      tick(15); toggle();
    end
    tick(3);
    chk("R10 captured config used", state_o, 3);

    // random preambles
    for (int t = 0; t < 40; t++) begin
      int b, lo, hi, need, n, ex;
      b = 1 + int'($urandom_range(2));
      lo = 3 + int'($urandom_range(12));
      hi = lo + int'($urandom_range(12));
      need = 6 * b;
      n = need + 2;
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(9) < 9) iv[i] = lo + int'($urandom_range(hi - lo));
        else if ($urandom_range(1) == 0) iv[i] = lo - 1 - int'($urandom_range(1));
        else iv[i] = hi + 1 + int'($urandom_range(2));
        if (iv[i] < 1) iv[i] = 1;
      end
      ex = expect_recv(need, lo, hi, n);
      do_reset();
      start(2'(b), lo, hi);
      toggle();
      for (int i = 0; i < n; i++) begin
        tick(iv[i]); toggle();
      end
      tick(hi + 10);
      chk("R8 random preamble outcome (R5 R6 R7)", state_o, (ex == 3) ? 3 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule